// File: doc/BRIEF.md
# Multiplexed Scan Chain Test Sequencer

This block holds the state registers of a piece of logic as one or more serial chains of multiplexed-data flip-flops, and runs the scan test loop on them by itself. While idle, every cell takes its functional input on each clock, so the wrapped logic behaves normally. On a start request the sequencer raises test-enable and shifts one pattern into every chain. It then drops test-enable for a programmable settle time and issues a single capture cycle that loads the functional responses. After that it shifts again, which unloads the response and loads the next pattern on the same clocks. After the last pattern it runs one final unload window and then raises a done flag.

All chains share one test-enable. Chains may differ in length. A shorter chain receives padding bits first, so every chain finishes loading on the same clock. A separate flush request runs a chain-integrity test: the chains are cleared and then shifted for twice the longest chain length, and the serial stream must reappear at each scan output after exactly that chain's length. While any scan activity is in progress, the functional asynchronous clear of the cells is blocked. Whenever test-enable is high, the write enable passed to an attached memory is forced low.

Top module: `scan_test_sequencer`

## Requirements
- R1: While test_en is 1, every cell takes the value of its predecessor on each clock, and cell 0 of chain c takes scan_in[c]. After the MAX_LEN shift clocks of a load window, cell k of the longest chain holds the bit driven at shift position MAX_LEN-1-k. Positions count from 0 within the window, and func_q exposes the cells.
- R2: Chain c has length MAX_LEN - c*LEN_STEP and occupies func_q bits starting at the sum of the lengths of the chains before it. Every chain shifts in the same MAX_LEN-clock window, so the first bits of a shorter chain are padding, and its cell k holds the bit of position MAX_LEN-1-k.
- R3: After a load window, test_en stays 0 for max(settle_cycles,1) clocks without capture. Then cap_strobe is 1 for exactly one clock, on whose closing edge every cell loads func_d.
- R4: The shift window that follows a capture unloads the response. At shift position j < length L of chain c, scan_out[c] shows the captured bit of cell L-1-j. The same clocks load the next pattern.
- R5: A run performs exactly pat_count captures. When pat_count is 0, done rises on the clock after start and no shifting takes place.
- R6: done becomes 1 on the clock that ends the final unload window, and stays 1 with test_en 0 until the next start or flush request.
- R7: A flush request gives one clear clock, then 2*MAX_LEN clocks with test_en 1. At flush position j, scan_out[c] is 0 for j < L, and for larger j it equals the scan_in[c] bit of position j-L.
- R8: func_clr_n low clears all cells at once while no scan activity is in progress. During a load, settle, capture or flush it has no effect on the cells.
- R9: mem_we_out equals mem_we_in when test_en is 0, and is 0 when test_en is 1.
- R10: Outside a run, test_en and cap_strobe are 0 and every cell loads func_d on each clock. Reset clears all cells.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a scan test run |
| flush_start | input | 1 | Begin a chain integrity test |
| pat_count | input | PAT_W | Number of patterns in a run |
| settle_cycles | input | SETTLE_W | Settle clocks before capture (0 treated as 1) |
| scan_in | input | NUM_CHAINS | Serial input, one bit per chain |
| func_d | input | TOTAL | Functional next-state values from the wrapped logic |
| func_clr_n | input | 1 | Functional asynchronous clear, active low |
| mem_we_in | input | 1 | Memory write enable from the functional logic |
| scan_out | output | NUM_CHAINS | Serial output, last cell of each chain |
| test_en | output | 1 | Shared scan shift enable |
| cap_strobe | output | 1 | High during the single capture clock |
| func_q | output | TOTAL | Cell contents to the wrapped logic |
| mem_we_out | output | 1 | Gated memory write enable |
| done | output | 1 | Run complete |

## Verification
The bench goes after the boundaries of the shift window. A wrong order in the chain would reverse the loaded word. A shorter chain without padding would keep the first bits instead of the last. An unload counted off by one would show each response bit one position early. It runs settle_cycles of 0, where a design that skipped the minimum would capture straight after the shift. It also runs pat_count values of 0 and 1, where a wrong pattern counter would add or drop a capture and raise done a window late or early. It pulls the functional clear during settle, where an ungated clear would wipe the pattern just before capture. The flush run checks that the cleared zeros drain first and that each chain delays the stream by exactly its own length.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_FCLR   = 3'd1,
    ST_FSHIFT = 3'd2,
    ST_LOAD   = 3'd3,
    ST_SETTLE = 3'd4,
    ST_CAPT   = 3'd5,
    ST_UNLOAD = 3'd6,
    ST_DONE   = 3'd7
  } seq_state_e;

  // length of chain c: the first chain is the longest, each next one shorter by step
  function automatic int chain_len(int max_len, int step, int c);
    return max_len - c * step;
  endfunction

  // first func_q bit of chain c
  function automatic int chain_base(int max_len, int step, int c);
    int acc;
    acc = 0;
    for (int i = 0; i < c; i++) acc += chain_len(max_len, step, i);
    return acc;
  endfunction

  function automatic int total_bits(int max_len, int step, int n);
    return chain_base(max_len, step, n);
  endfunction

endpackage

// File: rtl/scan_seq_ctrl.sv
module scan_seq_ctrl
  import scan_seq_pkg::*;
#(
  parameter int MAX_LEN  = 8,
  parameter int PAT_W    = 8,
  parameter int SETTLE_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                flush_start,
  input  logic [PAT_W-1:0]    pat_count,
  input  logic [SETTLE_W-1:0] settle_cycles,
  output logic                test_en,
  output logic                cap_strobe,
  output logic                done,
  output logic                scan_mode,
  output logic                zero_en,
  output logic                load_en,
  output logic                window_last,
  output logic                settle_last
);

  localparam int FLUSH_LEN = 2 * MAX_LEN;
  localparam int CNT_W     = $clog2(FLUSH_LEN + 1);

  function automatic logic [SETTLE_W-1:0] settle_limit(logic [SETTLE_W-1:0] v);
    return (v == '0) ? SETTLE_W'(1) : v;
  endfunction

  seq_state_e          state_q, state_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [SETTLE_W-1:0] stl_q, stl_d;
  logic [SETTLE_W-1:0] stl_lim_q, stl_lim_d;
  logic [PAT_W-1:0]    pat_q, pat_d;
  logic                flush_last;

  assign window_last = (cnt_q == CNT_W'(MAX_LEN - 1));
  assign flush_last  = (cnt_q == CNT_W'(FLUSH_LEN - 1));
  assign settle_last = (stl_q == stl_lim_q - SETTLE_W'(1));

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    stl_d     = stl_q;
    stl_lim_d = stl_lim_q;
    pat_d     = pat_q;
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        if (flush_start) begin
          state_d = ST_FCLR;
        end else if (start) begin
          stl_lim_d = settle_limit(settle_cycles);
          pat_d     = pat_count;
          cnt_d     = '0;
          state_d   = (pat_count == '0) ? ST_DONE : ST_LOAD;
        end
      end
      ST_FCLR: begin
        cnt_d   = '0;
        state_d = ST_FSHIFT;
      end
      ST_FSHIFT: begin
        cnt_d = cnt_q + CNT_W'(1);
        if (flush_last) state_d = ST_IDLE;
      end
      ST_LOAD: begin
        cnt_d = cnt_q + CNT_W'(1);
        if (window_last) begin
          stl_d   = '0;
          state_d = ST_SETTLE;
        end
      end
      ST_SETTLE: begin
        stl_d = stl_q + SETTLE_W'(1);
        if (settle_last) state_d = ST_CAPT;
      end
      ST_CAPT: begin
        pat_d   = pat_q - PAT_W'(1);
        cnt_d   = '0;
        state_d = (pat_q == PAT_W'(1)) ? ST_UNLOAD : ST_LOAD;
      end
      ST_UNLOAD: begin
        cnt_d = cnt_q + CNT_W'(1);
        if (window_last) state_d = ST_DONE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      stl_q     <= '0;
      stl_lim_q <= SETTLE_W'(1);
      pat_q     <= '0;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      stl_q     <= stl_d;
      stl_lim_q <= stl_lim_d;
      pat_q     <= pat_d;
    end
  end

  assign test_en    = (state_q == ST_LOAD) || (state_q == ST_UNLOAD) || (state_q == ST_FSHIFT);
  assign cap_strobe = (state_q == ST_CAPT);
  assign done       = (state_q == ST_DONE);
  assign scan_mode  = (state_q != ST_IDLE) && (state_q != ST_DONE);
  assign zero_en    = (state_q == ST_FCLR);
  assign load_en    = !scan_mode || cap_strobe;

endmodule

// File: rtl/scan_cell_bank.sv
module scan_cell_bank
  import scan_seq_pkg::*;
#(
  parameter int NUM_CHAINS = 2,
  parameter int MAX_LEN    = 8,
  parameter int LEN_STEP   = 3,
  parameter int TOTAL      = 13
) (
  input  logic                  clk,
  input  logic                  cell_clr_n,
  input  logic                  shift_en,
  input  logic                  load_en,
  input  logic                  zero_en,
  input  logic [NUM_CHAINS-1:0] scan_in,
  input  logic [TOTAL-1:0]      func_d,
  output logic [TOTAL-1:0]      func_q,
  output logic [NUM_CHAINS-1:0] scan_out
);

  for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_chain
    localparam int L = chain_len(MAX_LEN, LEN_STEP, c);
    localparam int B = chain_base(MAX_LEN, LEN_STEP, c);

    logic [L-1:0] cq;
    logic [L-1:0] shifted;

    if (L == 1) begin : g_single
      assign shifted = scan_in[c];
    end else begin : g_multi
      assign shifted = {cq[L-2:0], scan_in[c]};
    end

    always_ff @(posedge clk or negedge cell_clr_n) begin
      if (!cell_clr_n)   cq <= '0;
      else if (zero_en)  cq <= '0;
      else if (shift_en) cq <= shifted;
      else if (load_en)  cq <= func_d[B +: L];
    end

    assign func_q[B +: L] = cq;
    assign scan_out[c]    = cq[L-1];
  end

endmodule

// File: rtl/scan_safety_gate.sv
module scan_safety_gate (
  input  logic rst_n,
  input  logic func_clr_n,
  input  logic scan_mode,
  input  logic test_en,
  input  logic mem_we_in,
  output logic cell_clr_n,
  output logic mem_we_out
);

  // functional clear only reaches the cells outside scan activity
  assign cell_clr_n = rst_n && (func_clr_n || scan_mode);
  // no memory writes while the chains shift
  assign mem_we_out = mem_we_in && !test_en;

endmodule

// File: rtl/scan_test_sequencer.sv
module scan_test_sequencer
  import scan_seq_pkg::*;
#(
  parameter int NUM_CHAINS = 2,
  parameter int MAX_LEN    = 8,
  parameter int LEN_STEP   = 3,
  parameter int PAT_W      = 8,
  parameter int SETTLE_W   = 4,
  localparam int TOTAL     = total_bits(MAX_LEN, LEN_STEP, NUM_CHAINS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  flush_start,
  input  logic [PAT_W-1:0]      pat_count,
  input  logic [SETTLE_W-1:0]   settle_cycles,
  input  logic [NUM_CHAINS-1:0] scan_in,
  input  logic [TOTAL-1:0]      func_d,
  input  logic                  func_clr_n,
  input  logic                  mem_we_in,
  output logic [NUM_CHAINS-1:0] scan_out,
  output logic                  test_en,
  output logic                  cap_strobe,
  output logic [TOTAL-1:0]      func_q,
  output logic                  mem_we_out,
  output logic                  done
);

  // internal events brought out for the checker
  logic scan_mode;
  logic zero_en;
  logic load_en;
  logic window_last;
  logic settle_last;
  logic cell_clr_n;

  scan_seq_ctrl #(
    .MAX_LEN (MAX_LEN),
    .PAT_W   (PAT_W),
    .SETTLE_W(SETTLE_W)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .flush_start  (flush_start),
    .pat_count    (pat_count),
    .settle_cycles(settle_cycles),
    .test_en      (test_en),
    .cap_strobe   (cap_strobe),
    .done         (done),
    .scan_mode    (scan_mode),
    .zero_en      (zero_en),
    .load_en      (load_en),
    .window_last  (window_last),
    .settle_last  (settle_last)
  );

  scan_safety_gate u_gate (
    .rst_n     (rst_n),
    .func_clr_n(func_clr_n),
    .scan_mode (scan_mode),
    .test_en   (test_en),
    .mem_we_in (mem_we_in),
    .cell_clr_n(cell_clr_n),
    .mem_we_out(mem_we_out)
  );

  scan_cell_bank #(
    .NUM_CHAINS(NUM_CHAINS),
    .MAX_LEN   (MAX_LEN),
    .LEN_STEP  (LEN_STEP),
    .TOTAL     (TOTAL)
  ) u_bank (
    .clk       (clk),
    .cell_clr_n(cell_clr_n),
    .shift_en  (test_en),
    .load_en   (load_en),
    .zero_en   (zero_en),
    .scan_in   (scan_in),
    .func_d    (func_d),
    .func_q    (func_q),
    .scan_out  (scan_out)
  );

endmodule

// File: rtl/scan_test_sequencer_chk.sv
module scan_test_sequencer_chk (
  input logic clk,
  input logic rst_n,
  input logic test_en,
  input logic cap_strobe,
  input logic done,
  input logic scan_mode,
  input logic cell_clr_n,
  input logic mem_we_out
);

  assert_we_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    test_en |-> !mem_we_out);

  assert_clear_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    scan_mode |-> cell_clr_n);

  assert_single_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cap_strobe |=> !cap_strobe);

  assert_settle_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cap_strobe |-> !$past(test_en));

  assert_done_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!test_en && !cap_strobe));

  assert_idle_no_shift_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_mode |-> !test_en);

endmodule

bind scan_test_sequencer scan_test_sequencer_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .test_en   (test_en),
  .cap_strobe(cap_strobe),
  .done      (done),
  .scan_mode (scan_mode),
  .cell_clr_n(cell_clr_n),
  .mem_we_out(mem_we_out)
);

// File: tb/sim_scan_test_sequencer.sv
module sim_scan_test_sequencer;

  localparam int CLK_PERIOD = 10;
  localparam int NCH  = 2;
  localparam int MLEN = 8;
  localparam int STEP = 3;
  localparam int TOT  = 13;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic            flush_start = 1'b0;
  logic [7:0]      pat_count = '0;
  logic [3:0]      settle_cycles = '0;
  logic [NCH-1:0]  scan_in = '0;
  logic [TOT-1:0]  func_d;
  logic            func_clr_n = 1'b1;
  logic            mem_we_in = 1'b1;
  logic [NCH-1:0]  scan_out;
  logic            test_en;
  logic            cap_strobe;
  logic [TOT-1:0]  func_q;
  logic            mem_we_out;
  logic            done;

  int checks = 0;
  int fails = 0;
  bit ended = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic int len_of(int c);
    return MLEN - STEP * c;
  endfunction

  function automatic int base_of(int c);
    return (c == 0) ? 0 : MLEN;
  endfunction

  // wrapped combinational logic: rotate left by one, then invert a fixed set of bits
  function automatic logic [TOT-1:0] wrapped_logic(logic [TOT-1:0] v);
    return {v[TOT-2:0], v[TOT-1]} ^ 13'h0A53;
  endfunction

  assign func_d = wrapped_logic(func_q);

  scan_test_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .flush_start(flush_start),
    .pat_count(pat_count), .settle_cycles(settle_cycles), .scan_in(scan_in),
    .func_d(func_d), .func_clr_n(func_clr_n), .mem_we_in(mem_we_in),
    .scan_out(scan_out), .test_en(test_en), .cap_strobe(cap_strobe),
    .func_q(func_q), .mem_we_out(mem_we_out), .done(done)
  );

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  logic [MLEN-1:0] pats [8][NCH];

  task automatic run_scan(int npat, int settle);
    int win = 0, j = 0, caps = 0, gap = 0, guard = 0;
    int eff;
    logic te, te_prev = 1'b0;
    logic [TOT-1:0] loaded = '0, resp = '0;
    eff = (settle == 0) ? 1 : settle;
    for (int p = 0; p < 8; p++)
      for (int c = 0; c < NCH; c++) pats[p][c] = MLEN'($urandom);
    pat_count = 8'(npat);
    settle_cycles = 4'(settle);
    @(negedge clk);
    start = 1'b1;
    forever begin
      @(negedge clk);
      start = 1'b0;
      guard++;
      te = test_en;
      check(mem_we_out == (mem_we_in && !te), "R9 write gate", 32'(mem_we_out), 32'(mem_we_in && !te));
      if (npat == 0) begin
        check(done && !te, "R5 zero patterns", {30'd0, done, te}, 32'h2);
        break;
      end
      if (te && !te_prev) j = 0;
      if (te) begin
        for (int c = 0; c < NCH; c++) begin
          if (win > 0 && j < len_of(c))
            check(scan_out[c] == resp[base_of(c) + len_of(c) - 1 - j], "R4 unload",
                  32'(scan_out[c]), 32'(resp[base_of(c) + len_of(c) - 1 - j]));
          scan_in[c] = (win < npat) ? pats[win][c][j] : 1'($urandom);
        end
        j++;
      end
      if (!te && te_prev) begin
        win++;
        gap = 0;
        if (win <= npat) begin
          for (int c = 0; c < NCH; c++)
            for (int k = 0; k < len_of(c); k++)
              loaded[base_of(c) + k] = pats[win-1][c][MLEN-1-k];
          check(func_q[MLEN-1:0] == loaded[MLEN-1:0], "R1 load chain0",
                32'(func_q[MLEN-1:0]), 32'(loaded[MLEN-1:0]));
          check(func_q[TOT-1:MLEN] == loaded[TOT-1:MLEN], "R2 padded chain1",
                32'(func_q[TOT-1:MLEN]), 32'(loaded[TOT-1:MLEN]));
        end else begin
          check(done == 1'b1, "R6 done after unload", 32'(done), 32'd1);
          check(caps == npat, "R5 capture count", 32'(caps), 32'(npat));
          break;
        end
      end
      if (!te && !cap_strobe && !done && win >= 1 && win <= npat) begin
        gap++;
        if (gap == 1) func_clr_n = 1'b0;
      end
      if (cap_strobe) begin
        func_clr_n = 1'b1;
        check(gap == eff, "R3 settle length", 32'(gap), 32'(eff));
        check(func_q == loaded, "R8 clear blocked in scan", 32'(func_q), 32'(loaded));
        resp = wrapped_logic(loaded);
        caps++;
      end
      te_prev = te;
      if (guard > 2000) begin
        check(1'b0, "R6 run timeout", 32'(guard), 32'd0);
        break;
      end
    end
    func_clr_n = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check(done && !test_en, "R6 done held", {30'd0, done, test_en}, 32'h2);
    end
  endtask

  task automatic run_flush();
    logic [2*MLEN-1:0] sent [NCH];
    int j = 0, guard = 0;
    bit seen = 0;
    @(negedge clk);
    flush_start = 1'b1;
    forever begin
      @(negedge clk);
      flush_start = 1'b0;
      guard++;
      if (test_en) begin
        seen = 1;
        for (int c = 0; c < NCH; c++) begin
          logic expv;
          expv = (j < len_of(c)) ? 1'b0 : sent[c][j - len_of(c)];
          check(scan_out[c] == expv, "R7 flush stream", 32'(scan_out[c]), 32'(expv));
          sent[c][j] = 1'($urandom);
          scan_in[c] = sent[c][j];
        end
        j++;
      end else if (seen) begin
        check(j == 2 * MLEN, "R7 flush length", 32'(j), 32'(2 * MLEN));
        break;
      end
      if (guard > 200) begin
        check(1'b0, "R7 flush timeout", 32'(guard), 32'd0);
        break;
      end
    end
  endtask

  initial begin
    logic [TOT-1:0] expq;
    void'($urandom(32'd1234));
    #(CLK_PERIOD * 2);
    check(func_q == '0 && !test_en && !cap_strobe && !done, "R10 reset state",
          32'(func_q), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    expq = '0;
    repeat (3) begin
      @(negedge clk);
      expq = wrapped_logic(expq);
      check(func_q == expq, "R10 functional load", 32'(func_q), 32'(expq));
    end
    func_clr_n = 1'b0;
    #1;
    check(func_q == '0, "R8 idle clear", 32'(func_q), 32'd0);
    @(negedge clk);
    func_clr_n = 1'b1;
    @(negedge clk);
    check(func_q == wrapped_logic('0), "R10 after clear", 32'(func_q), 32'(wrapped_logic('0)));

    run_flush();
    run_scan(1, 0);
    run_scan(0, 3);
    run_scan(3, 1);
    for (int r = 0; r < 4; r++) run_scan(1 + int'($urandom % 4), int'($urandom % 6));
    run_scan(2, 15);
    run_flush();
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      summary();
    end
  end

endmodule